// File: doc/BRIEF.md
# Per-Bank Distributed Refresh Scheduler

This block decides when each bank of a multi-bank DRAM gets its next row refresh. The retention window, as a cycle count, is divided by the number of rows to give a refresh interval. Each bank keeps its own countdown timer, its own count of owed refreshes and its own row pointer. When a bank's timer runs out, one row of that bank is refreshed. The whole array is never refreshed in a single burst. The bank phases are offset from one another by a quarter of the interval (interval divided by bank count), so no two banks fall due in the same cycle.

A refresh occupies only its own bank, for a fixed busy time. With the default values (4 busy cycles in a 120-cycle interval) that is about 3.3 % of each bank's time. Host read or write requests to the other banks keep being accepted while it runs. Host requests win over a due refresh. A refresh may be put off for up to a set number of intervals. After that it is forced, and a host request to that bank is stalled.

When the host asks for sleep, the scheduler stops issuing refreshes, waits until no bank is busy, and hands refresh duty to the memory's self-refresh mode. On wake it restarts every bank timer with at least one full interval and continues from each bank's saved row.

Top module: `rfsh_sched`

## Requirements
- R1: After reset, `ref_valid`, `bank_busy`, `sr_active`, `sr_enter` and `sr_exit` are 0, and `req_ready` is 1.
- R2: With no host traffic, each bank receives exactly one refresh every INTERVAL = RETENTION_CYC/ROWS cycles (120 by default).
- R3: Bank b's first refresh after reset is presented (b+1)*STAGGER+1 cycles after reset release, where STAGGER = INTERVAL/NUM_BANKS. Banks are therefore STAGGER cycles apart.
- R4: `ref_row` gives the bank's row pointer in binary, and `ref_bank` gives the bank number in binary. Each bank's row pointer starts at 0, advances by one per refresh of that bank, and wraps from ROWS-1 to 0.
- R5: `bank_busy[b]` is high for exactly BUSY_CYC cycles, starting in the cycle in which the refresh of bank b is presented on `ref_valid`.
- R6: A request to a bank that is not busy has `req_ready` high in the same cycle, even while another bank is refreshing.
- R7: A request to a busy bank has `req_ready` low until that bank's busy time ends. It is accepted in the first cycle the bank is free.
- R8: A host request to a bank defers that bank's due refresh. When MAX_POSTPONE+1 refreshes are owed, the refresh is forced: `req_ready` is low in that cycle and the refresh is presented in the next cycle.
- R9: Once the host stops requesting, the owed refreshes of a bank are issued one after another. Each follows the previous one's busy time by one cycle.
- R10: With `sleep_req` high and no bank busy, `sr_active` rises in the next cycle together with a one-cycle `sr_enter` pulse. While `sr_active` is high, no refresh is issued and `req_ready` is low.
- R11: When `sleep_req` drops, `sr_active` falls in the next cycle together with a one-cycle `sr_exit` pulse. Bank b's next refresh comes INTERVAL+1+b*STAGGER cycles after that pulse and uses the row saved before sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host has a read or write request |
| req_bank | input | BANK_W | Bank addressed by the host request |
| req_ready | output | 1 | Host request accepted this cycle |
| sleep_req | input | 1 | Host wants low-power sleep (level) |
| ref_valid | output | 1 | Row refresh command presented this cycle |
| ref_bank | output | BANK_W | Bank being refreshed |
| ref_row | output | ROW_W | Row being refreshed |
| bank_busy | output | NUM_BANKS | Per-bank refresh-in-progress flags |
| sr_active | output | 1 | Memory is in self-refresh |
| sr_enter | output | 1 | One-cycle pulse on entering self-refresh |
| sr_exit | output | 1 | One-cycle pulse on leaving self-refresh |

## Verification
A bank's refresh appears on `ref_valid` one cycle after the edge at which its timer expires. The busy flag is high for that cycle and the next BUSY_CYC-1 cycles. `req_ready` is combinational and is sampled 1 ns after the inputs change on the falling edge. The scoreboard computes the exact presentation cycle of every refresh from the interval, the stagger and the wake pulse, and compares cycle, bank and row at the falling edge of that cycle. The self-refresh pulses are checked in the cycle after the `sleep_req` change. The postponement checks sample the cycle in which the refresh becomes forced, the next cycle, and the catch-up cycles that follow a release of the host request.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_SELF = 1'b1
    } rfsh_mode_e;
endpackage

// File: rtl/rfsh_bank_ctl.sv
// Per-bank refresh bookkeeping: countdown timer, owed-refresh count,
// busy counter and row pointer.
module rfsh_bank_ctl #(
    parameter int TIMER_W    = 8,
    parameter int ROW_W      = 4,
    parameter int ROWS       = 16,
    parameter int BUSY_W     = 3,
    parameter int BUSY_CYC   = 4,
    parameter int FORCE_AT   = 3,
    parameter int PEND_W     = 2,
    parameter int START_LOAD = 29,
    parameter int RELOAD     = 119,
    parameter int WAKE_LOAD  = 119
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wake,
    input  logic             grant,
    output logic             due,
    output logic             force_now,
    output logic             busy,
    output logic [ROW_W-1:0] row
);
    typedef struct packed {
        logic [TIMER_W-1:0] timer;
        logic [PEND_W-1:0]  pend;
        logic [BUSY_W-1:0]  busy_cnt;
        logic [ROW_W-1:0]   row;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     tick;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;

        // Timer: reload on wake, count down while running.
        if (wake) begin
            st_d.timer = TIMER_W'(WAKE_LOAD);
            st_d.pend  = '0;
        end else if (run) begin
            if (st_q.timer == '0) begin
                tick       = 1'b1;
                st_d.timer = TIMER_W'(RELOAD);
            end else begin
                st_d.timer = st_q.timer - 1'b1;
            end
        end

        // Owed refreshes: one more per tick, one fewer per grant.
        if (tick && !grant) begin
            if (st_q.pend != PEND_W'(FORCE_AT)) begin
                st_d.pend = st_q.pend + 1'b1;
            end
        end else if (!tick && grant) begin
            st_d.pend = st_q.pend - 1'b1;
        end

        // Busy window.
        if (grant) begin
            st_d.busy_cnt = BUSY_W'(BUSY_CYC);
        end else if (st_q.busy_cnt != '0) begin
            st_d.busy_cnt = st_q.busy_cnt - 1'b1;
        end

        // Row pointer with wrap.
        if (grant) begin
            if (st_q.row == ROW_W'(ROWS - 1)) begin
                st_d.row = '0;
            end else begin
                st_d.row = st_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.timer    <= TIMER_W'(START_LOAD);
            st_q.pend     <= '0;
            st_q.busy_cnt <= '0;
            st_q.row      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.busy_cnt != '0);
    assign due       = (st_q.pend != '0) && !busy;
    assign force_now = (st_q.pend >= PEND_W'(FORCE_AT)) && !busy;
    assign row       = st_q.row;
endmodule

// File: rtl/rfsh_arb.sv
// Picks at most one bank to refresh per cycle; host requests win unless forced.
module rfsh_arb #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic                 allow,
    input  logic [NUM_BANKS-1:0] due,
    input  logic [NUM_BANKS-1:0] force_req,
    input  logic                 host_valid,
    input  logic [BANK_W-1:0]    host_bank,
    output logic [NUM_BANKS-1:0] grant,
    output logic [BANK_W-1:0]    grant_bank,
    output logic                 grant_any
);
    logic [NUM_BANKS-1:0] elig;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_elig
        assign elig[g] = allow && due[g] &&
                         (force_req[g] || !(host_valid && (host_bank == BANK_W'(g))));
    end

    always_comb begin
        grant      = '0;
        grant_bank = '0;
        grant_any  = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (elig[b] && !grant_any) begin
                grant[b]   = 1'b1;
                grant_bank = BANK_W'(b);
                grant_any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int ROWS          = 16,
    parameter int RETENTION_CYC = 1920,
    parameter int BUSY_CYC      = 4,
    parameter int MAX_POSTPONE  = 2,
    localparam int BANK_W       = $clog2(NUM_BANKS),
    localparam int ROW_W        = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    output logic                 req_ready,
    input  logic                 sleep_req,
    output logic                 ref_valid,
    output logic [BANK_W-1:0]    ref_bank,
    output logic [ROW_W-1:0]     ref_row,
    output logic [NUM_BANKS-1:0] bank_busy,
    output logic                 sr_active,
    output logic                 sr_enter,
    output logic                 sr_exit
);
    localparam int INTERVAL = RETENTION_CYC / ROWS;
    localparam int STAGGER  = INTERVAL / NUM_BANKS;
    localparam int TIMER_W  = $clog2(2 * INTERVAL);
    localparam int BUSY_W   = $clog2(BUSY_CYC + 1);
    localparam int FORCE_AT = MAX_POSTPONE + 1;
    localparam int PEND_W   = $clog2(FORCE_AT + 1);

    typedef struct packed {
        rfsh_mode_e        mode;
        logic              ref_valid;
        logic [BANK_W-1:0] ref_bank;
        logic [ROW_W-1:0]  ref_row;
        logic              sr_enter;
        logic              sr_exit;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic                 run, wake, allow;
    logic [NUM_BANKS-1:0] due, force_req, grant;
    logic [BANK_W-1:0]    grant_bank;
    logic                 grant_any;
    logic [ROW_W-1:0]     rows [NUM_BANKS];

    assign run   = (ctl_q.mode == MODE_RUN);
    assign wake  = (ctl_q.mode == MODE_SELF) && !sleep_req;
    assign allow = run && !sleep_req;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        rfsh_bank_ctl #(
            .TIMER_W   (TIMER_W),
            .ROW_W     (ROW_W),
            .ROWS      (ROWS),
            .BUSY_W    (BUSY_W),
            .BUSY_CYC  (BUSY_CYC),
            .FORCE_AT  (FORCE_AT),
            .PEND_W    (PEND_W),
            .START_LOAD((g + 1) * STAGGER - 1),
            .RELOAD    (INTERVAL - 1),
            .WAKE_LOAD (INTERVAL - 1 + g * STAGGER)
        ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .wake     (wake),
            .grant    (grant[g]),
            .due      (due[g]),
            .force_now(force_req[g]),
            .busy     (bank_busy[g]),
            .row      (rows[g])
        );
    end

    rfsh_arb #(
        .NUM_BANKS(NUM_BANKS),
        .BANK_W   (BANK_W)
    ) i_arb (
        .allow     (allow),
        .due       (due),
        .force_req (force_req),
        .host_valid(req_valid),
        .host_bank (req_bank),
        .grant     (grant),
        .grant_bank(grant_bank),
        .grant_any (grant_any)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.ref_valid = grant_any;
        ctl_d.ref_bank  = grant_bank;
        ctl_d.ref_row   = rows[grant_bank];
        ctl_d.sr_enter  = 1'b0;
        ctl_d.sr_exit   = 1'b0;
        case (ctl_q.mode)
            MODE_RUN: begin
                if (sleep_req && (bank_busy == '0)) begin
                    ctl_d.mode     = MODE_SELF;
                    ctl_d.sr_enter = 1'b1;
                end
            end
            MODE_SELF: begin
                if (!sleep_req) begin
                    ctl_d.mode    = MODE_RUN;
                    ctl_d.sr_exit = 1'b1;
                end
            end
            default: ctl_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.mode      <= MODE_RUN;
            ctl_q.ref_valid <= 1'b0;
            ctl_q.ref_bank  <= '0;
            ctl_q.ref_row   <= '0;
            ctl_q.sr_enter  <= 1'b0;
            ctl_q.sr_exit   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = run && !bank_busy[req_bank] && !grant[req_bank];
    assign ref_valid = ctl_q.ref_valid;
    assign ref_bank  = ctl_q.ref_bank;
    assign ref_row   = ctl_q.ref_row;
    assign sr_active = (ctl_q.mode == MODE_SELF);
    assign sr_enter  = ctl_q.sr_enter;
    assign sr_exit   = ctl_q.sr_exit;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [BANK_W-1:0]    req_bank,
    input logic                 req_ready,
    input logic                 sleep_req,
    input logic                 ref_valid,
    input logic [BANK_W-1:0]    ref_bank,
    input logic [NUM_BANKS-1:0] bank_busy,
    input logic                 sr_active,
    input logic                 sr_enter,
    input logic                 sr_exit
);
    a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bank_busy[req_bank]) |-> !req_ready);

    a_r5_busy_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> bank_busy[ref_bank]);

    a_r10_quiet_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> (!ref_valid && !req_ready));

    a_r10_enter_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sr_enter |-> (sr_active && !$past(sr_active)));

    a_r10_enter_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_active) |-> ($past(sleep_req) && ($past(bank_busy) == '0)));

    a_r11_exit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit |-> (!sr_active && $past(sr_active)));
endmodule

bind rfsh_sched rfsh_sched_chk #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_bank (req_bank),
    .req_ready(req_ready),
    .sleep_req(sleep_req),
    .ref_valid(ref_valid),
    .ref_bank (ref_bank),
    .bank_busy(bank_busy),
    .sr_active(sr_active),
    .sr_enter (sr_enter),
    .sr_exit  (sr_exit)
);

// File: tb/test_rfsh_sched.sv
`timescale 1ns/1ps
module test_rfsh_sched;
    localparam int NB       = 4;
    localparam int ROWS     = 16;
    localparam int INTERVAL = 120;
    localparam int STAGGER  = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_bank = '0;
    logic       req_ready;
    logic       sleep_req = 1'b0;
    logic       ref_valid;
    logic [1:0] ref_bank;
    logic [3:0] ref_row;
    logic [3:0] bank_busy;
    logic       sr_active, sr_enter, sr_exit;

    int checks = 0;
    int errors = 0;
    int cyc;
    int cnt_b0 = 0;
    int cnt_all = 0;
    bit sb_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int bank;
        int row;
        int at;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    rfsh_sched i_rfsh_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_bank (req_bank),
        .req_ready(req_ready),
        .sleep_req(sleep_req),
        .ref_valid(ref_valid),
        .ref_bank (ref_bank),
        .ref_row  (ref_row),
        .bank_busy(bank_busy),
        .sr_active(sr_active),
        .sr_enter (sr_enter),
        .sr_exit  (sr_exit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic push_exp(input int b, input int r, input int at);
        exp_t e;
        e.bank = b; e.row = r; e.at = at;
        sbq.push_back(e);
    endtask

    // Monitor: compares every refresh command against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && ref_valid) begin
            cnt_all++;
            if (ref_bank == 2'd0) cnt_b0++;
            if (sb_on) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R2/R3 unexpected refresh", cyc, -1);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(cyc == e.at, "R2/R3 refresh cycle", cyc, e.at);
                    check(int'(ref_bank) == e.bank, "R3 refresh bank", int'(ref_bank), e.bank);
                    check(int'(ref_row) == e.row, "R4 refresh row", int'(ref_row), e.row);
                end
            end
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(ref_valid == 1'b0, "R1 ref_valid", ref_valid, 0);
        check(bank_busy == 4'b0, "R1 bank_busy", bank_busy, 0);
        check(sr_active == 1'b0 && sr_enter == 1'b0 && sr_exit == 1'b0, "R1 self-refresh flags",
              {sr_active, sr_enter, sr_exit}, 0);
        check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);

        // Phase A: undisturbed schedule, 17 refreshes per bank (row wrap).
        for (int k = 0; k < 17; k++)
            for (int b = 0; b < NB; b++)
                push_exp(b, k % ROWS, STAGGER + 1 + b * STAGGER + k * INTERVAL);
        sb_on = 1'b1;

        wait_until(31);
        check(bank_busy[0] == 1'b1, "R5 busy on command cycle", bank_busy[0], 1);
        req_valid = 1'b1; req_bank = 2'd0; #1;
        check(req_ready == 1'b0, "R7 held while bank busy", req_ready, 0);
        @(negedge clk);
        req_bank = 2'd1; #1;
        check(req_ready == 1'b1, "R6 other bank accepted", req_ready, 1);
        check(bank_busy[0] == 1'b1, "R5 busy second cycle", bank_busy[0], 1);
        @(negedge clk);
        req_bank = 2'd0; #1;
        check(req_ready == 1'b0, "R7 still held", req_ready, 0);
        @(negedge clk); #1;
        check(req_ready == 1'b0 && bank_busy[0] == 1'b1, "R5/R7 last busy cycle",
              {req_ready, bank_busy[0]}, 1);
        @(negedge clk); #1;
        check(cyc == 35, "R5 busy end cycle", cyc, 35);
        check(bank_busy[0] == 1'b0, "R5 busy cleared after BUSY_CYC", bank_busy[0], 0);
        check(req_ready == 1'b1, "R7 accepted when bank free", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;

        wait_until(2050);
        sb_on = 1'b0;
        check(sbq.size() == 0, "R2 all scheduled refreshes seen", sbq.size(), 0);

        // Phase B: host holds bank 0 from its refresh at cycle 2071.
        wait_until(2071);
        check(ref_valid && ref_bank == 2'd0 && ref_row == 4'd1, "R2/R4 bank0 refresh at 2071",
              {ref_valid, ref_bank, ref_row}, {1'b1, 2'd0, 4'd1});
        req_valid = 1'b1; req_bank = 2'd0;
        wait_until(2076);
        base = cnt_b0;
        wait_until(2101);
        check(ref_valid && ref_bank == 2'd1 && ref_row == 4'd1, "R6 bank1 refresh during host hold",
              {ref_valid, ref_bank, ref_row}, {1'b1, 2'd1, 4'd1});
        wait_until(2190); #1;
        check(req_ready == 1'b1, "R8 host wins over due refresh", req_ready, 1);
        wait_until(2430); #1;
        check(cnt_b0 == base, "R8 bank0 refreshes deferred", cnt_b0 - base, 0);
        check(req_ready == 1'b0, "R8 forced refresh stalls host", req_ready, 0);
        wait_until(2431);
        check(ref_valid && ref_bank == 2'd0 && ref_row == 4'd2, "R8 forced refresh issued",
              {ref_valid, ref_bank, ref_row}, {1'b1, 2'd0, 4'd2});
        wait_until(2436);
        req_valid = 1'b0;
        wait_until(2437);
        check(ref_valid && ref_bank == 2'd0 && ref_row == 4'd3, "R9 first catch-up refresh",
              {ref_valid, ref_bank, ref_row}, {1'b1, 2'd0, 4'd3});
        wait_until(2441);
        check(ref_valid == 1'b0, "R9 no refresh inside busy time", ref_valid, 0);
        wait_until(2442);
        check(ref_valid && ref_bank == 2'd0 && ref_row == 4'd4, "R9 second catch-up refresh",
              {ref_valid, ref_bank, ref_row}, {1'b1, 2'd0, 4'd4});

        // Phase C: sleep and wake.
        wait_until(2465);
        sleep_req = 1'b1;
        wait_until(2466);
        check(sr_active && sr_enter, "R10 enter self-refresh", {sr_active, sr_enter}, 3);
        wait_until(2467);
        check(sr_active && !sr_enter, "R10 enter pulse one cycle", {sr_active, sr_enter}, 2);
        wait_until(2470);
        base = cnt_all;
        wait_until(2500);
        req_valid = 1'b1; req_bank = 2'd2; #1;
        check(req_ready == 1'b0, "R10 host stalled in self-refresh", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        wait_until(2965);
        check(cnt_all == base, "R10 no refresh while asleep", cnt_all - base, 0);
        sleep_req = 1'b0;
        for (int k = 0; k < 2; k++) begin
            push_exp(0, 5 + k, 2966 + INTERVAL + 1 + 0 * STAGGER + k * INTERVAL);
            push_exp(1, 5 + k, 2966 + INTERVAL + 1 + 1 * STAGGER + k * INTERVAL);
            push_exp(2, 4 + k, 2966 + INTERVAL + 1 + 2 * STAGGER + k * INTERVAL);
            push_exp(3, 4 + k, 2966 + INTERVAL + 1 + 3 * STAGGER + k * INTERVAL);
        end
        wait_until(2966);
        sb_on = 1'b1;
        check(!sr_active && sr_exit, "R11 leave self-refresh", {sr_active, sr_exit}, 1);
        wait_until(2967);
        check(sr_exit == 1'b0, "R11 exit pulse one cycle", sr_exit, 0);
        wait_until(3310);
        check(sbq.size() == 0, "R11 resumed schedule complete", sbq.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule